// File: doc/BRIEF.md
# Event Record Log Buffer

This block turns alert activity into fixed-format event records and holds them in two small on-chip queues that a host drains one entry at a time. Each record carries a timestamp from a free-running cycle tick, the channel that raised it, the channel's measured value at the moment of the trigger, and a cause code. Records come from per-channel critical and warning trigger pulses, from any change of the operating mode input, and from a host snapshot request.

Critical threshold events and mode changes land in the critical page; warnings and snapshots land in the warning page. A heavy stream of warnings therefore cannot push hard faults out of the log. A shared mode input selects how a full page behaves: it either refuses new records or drops its oldest one. Triggers are captured in the cycle they arrive and are committed one per cycle in a fixed priority order. Loss of any record is reported through per-page sticky overflow flags and a saturating lost-event counter.

Top module: `evt_log`

## Requirements
- R1: After reset both pages are empty, `rd_valid_o`, `full_o` and `ovf_o` are low, and `lost_o` is zero.
- R2: A record is formatted as timestamp = tick value in the cycle the trigger was sampled (the tick is 0 in the first cycle after reset and counts up by one per cycle), channel, `val_i` slice of that channel, and cause code. Cause codes are 1 for critical, 2 for warning, 3 for mode change and 4 for snapshot. A trigger sampled at one rising edge is readable at the port after the next rising edge, when no other record is queued ahead of it. `rd_valid_o` is high exactly when the selected page is not empty.
- R3: A change of `mode_i` writes a cause-3 record to the critical page with channel 0 and value `{old_mode, new_mode}` zero-extended. A `snap_i` pulse writes a cause-4 record to the warning page with channel `snap_ch_i` and that channel's value.
- R4: Critical triggers go to the critical page (`rd_page_i`=1) and warnings to the warning page (`rd_page_i`=0). Warning traffic, overflow included, never changes the critical page's level or contents.
- R5: Requests sampled in the same cycle are committed one per cycle in this order: critical channels lowest first, then the mode change, then warning channels lowest first, then the snapshot. All of them keep the timestamp of the cycle they arrived in.
- R6: With `circ_i` low, a push to a full page is refused and the stored entries are unchanged.
- R7: With `circ_i` high, a push to a full page replaces the oldest entry, so the page keeps the newest DEPTH records.
- R8: Every refused or overwritten record sets that page's bit of `ovf_o` (bit 0 warning, bit 1 critical) and adds one to `lost_o`, which saturates at its maximum. `ovf_o` stays set until `ovf_clr_i`. A set and a clear in the same cycle leave the bit set.
- R9: `lvl_warn_o` and `lvl_crit_o` give each page's entry count, and `full_o[p]` is high exactly when page p holds DEPTH entries.
- R10: `pop_i` removes the head of the page selected by `rd_page_i`, oldest first. A pop of an empty page has no effect. A pop and a push in the same cycle on a full page both take effect with no loss.
- R11: A trigger from a source whose earlier request is still waiting to be committed is dropped. It counts as a lost event against that source's page, and the earlier captured record is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| crit_i | input | NUM_CH | Per-channel critical trigger pulses |
| warn_i | input | NUM_CH | Per-channel warning trigger pulses |
| val_i | input | NUM_CH*VAL_W | Measured values, channel c at bits c*VAL_W upward |
| mode_i | input | 2 | Operating mode; any change creates a record |
| snap_i | input | 1 | Host snapshot request pulse |
| snap_ch_i | input | log2(NUM_CH) | Channel captured by a snapshot |
| circ_i | input | 1 | 1: overwrite oldest when full, 0: refuse when full |
| pop_i | input | 1 | Remove head of selected page |
| rd_page_i | input | 1 | Page selected for reading, 0 warning, 1 critical |
| ovf_clr_i | input | 1 | Clear both overflow flags |
| rd_valid_o | output | 1 | Selected page holds a record |
| rd_ts_o | output | TS_W | Head record timestamp |
| rd_ch_o | output | log2(NUM_CH) | Head record channel |
| rd_val_o | output | VAL_W | Head record value |
| rd_cause_o | output | 3 | Head record cause code |
| lvl_warn_o | output | log2(DEPTH+1) | Warning page entry count |
| lvl_crit_o | output | log2(DEPTH+1) | Critical page entry count |
| full_o | output | 2 | Page full flags, bit 0 warning, bit 1 critical |
| ovf_o | output | 2 | Sticky overflow flags per page |
| lost_o | output | LOST_W | Saturating lost-event count |

## Verification
First every channel raises a lone critical trigger and a lone warning trigger, then mode changes and snapshots are applied. This separates field formatting and page routing errors from channel indexing errors. A single cycle with mixed critical, warning, mode and snapshot requests shows whether the commit order and the shared timestamp hold. Sustained single-channel bursts past the page depth are run in both full-page modes, and retained payloads tell refusal apart from replacement of the oldest entry. Pops on an empty page, a pop that coincides with a push into a full page, a retrigger while a request is still queued, and enough losses to saturate the counter cover the remaining boundaries.

// File: rtl/evt_log_pkg.sv
package evt_log_pkg;
  localparam int CAUSE_W = 3;
  localparam int MODE_W  = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_CRIT = 3'd1,
    CAUSE_WARN = 3'd2,
    CAUSE_MODE = 3'd3,
    CAUSE_SNAP = 3'd4
  } cause_e;
endpackage

// File: rtl/evt_page.sv
module evt_page #(
  parameter int DEPTH = 16,
  parameter int REC_W = 37,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             circ_i,
  input  logic             push_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic             pop_i,
  output logic [REC_W-1:0] head_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             lost_o
);
  logic [REC_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_pop, wr_en, ovw;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (int'(cnt_q) == DEPTH);
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i && !empty_o;
  // slot is free, freed this cycle, or the oldest is sacrificed
  assign ovw     = push_i && full_o && !do_pop && circ_i;
  assign wr_en   = push_i && (!full_o || do_pop || circ_i);
  assign lost_o  = push_i && full_o && !do_pop;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wp_q] <= rec_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= nxt(wp_q);
      if (do_pop || ovw) rp_q <= nxt(rp_q);
      if (wr_en && !ovw && !do_pop) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !wr_en) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o = mem_q[rp_q];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/evt_src.sv
module evt_src #(
  parameter int N = 10,
  parameter int W = 37
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   req_i,
  input  logic [N*W-1:0] rec_i,
  input  logic [N-1:0]   gnt_i,
  output logic [N-1:0]   pend_o,
  output logic [N*W-1:0] rec_o,
  output logic [N-1:0]   drop_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic pend_q, busy;
    logic [W-1:0] rec_q;

    assign busy      = pend_q && !gnt_i[g];
    assign drop_o[g] = req_i[g] && busy;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        rec_q  <= '0;
      end else begin
        pend_q <= busy || req_i[g];
        if (req_i[g] && !busy) rec_q <= rec_i[g*W +: W];
      end
    end

    assign pend_o[g]        = pend_q;
    assign rec_o[g*W +: W]  = rec_q;
  end
endmodule

// File: rtl/evt_arb.sv
module evt_arb #(
  parameter int N  = 10,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        any_o    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_log.sv
module evt_log
  import evt_log_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int VAL_W  = 16,
  parameter int TS_W   = 16,
  parameter int DEPTH  = 16,
  parameter int LOST_W = 8,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH-1:0]       crit_i,
  input  logic [NUM_CH-1:0]       warn_i,
  input  logic [NUM_CH*VAL_W-1:0] val_i,
  input  logic [MODE_W-1:0]       mode_i,
  input  logic                    snap_i,
  input  logic [CH_W-1:0]         snap_ch_i,
  input  logic                    circ_i,
  input  logic                    pop_i,
  input  logic                    rd_page_i,
  input  logic                    ovf_clr_i,
  output logic                    rd_valid_o,
  output logic [TS_W-1:0]         rd_ts_o,
  output logic [CH_W-1:0]         rd_ch_o,
  output logic [VAL_W-1:0]        rd_val_o,
  output logic [CAUSE_W-1:0]      rd_cause_o,
  output logic [CNT_W-1:0]        lvl_warn_o,
  output logic [CNT_W-1:0]        lvl_crit_o,
  output logic [1:0]              full_o,
  output logic [1:0]              ovf_o,
  output logic [LOST_W-1:0]       lost_o
);
  localparam int REC_W  = TS_W + CH_W + VAL_W + CAUSE_W;
  localparam int NSRC   = 2 * NUM_CH + 2;
  localparam int IDX_W  = $clog2(NSRC);
  localparam int MODE_I = NUM_CH;          // crit 0..NUM_CH-1, mode, warn, snap
  localparam int WARN_0 = NUM_CH + 1;
  localparam int SNAP_I = 2 * NUM_CH + 1;
  localparam int LOST_MAX = (1 << LOST_W) - 1;

  logic [TS_W-1:0]       tick_q;
  logic [MODE_W-1:0]     mode_q;
  logic [NSRC-1:0]       req, pend, gnt, drop;
  logic [NSRC*REC_W-1:0] rec_in, rec_pend;
  logic [IDX_W-1:0]      gidx;
  logic                  gany;
  logic [REC_W-1:0]      sel_rec;
  logic [1:0]            push, pop, empty, plost, sdrop;
  logic [REC_W-1:0]      head [2];
  logic [CNT_W-1:0]      cnt [2];
  logic [LOST_W-1:0]     lost_q;
  logic [1:0]            ovf_q;
  int                    lost_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      mode_q <= '0;
    end else begin
      tick_q <= tick_q + 1'b1;
      mode_q <= mode_i;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign req[c]          = crit_i[c];
    assign req[WARN_0 + c] = warn_i[c];
    assign rec_in[c*REC_W +: REC_W] =
      {tick_q, CH_W'(c), val_i[c*VAL_W +: VAL_W], CAUSE_CRIT};
    assign rec_in[(WARN_0+c)*REC_W +: REC_W] =
      {tick_q, CH_W'(c), val_i[c*VAL_W +: VAL_W], CAUSE_WARN};
  end

  assign req[MODE_I] = (mode_i != mode_q);
  assign req[SNAP_I] = snap_i;
  assign rec_in[MODE_I*REC_W +: REC_W] =
    {tick_q, CH_W'(0), VAL_W'({mode_q, mode_i}), CAUSE_MODE};
  assign rec_in[SNAP_I*REC_W +: REC_W] =
    {tick_q, snap_ch_i, val_i[snap_ch_i*VAL_W +: VAL_W], CAUSE_SNAP};

  evt_src #(.N(NSRC), .W(REC_W)) u_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .rec_i  (rec_in),
    .gnt_i  (gnt),
    .pend_o (pend),
    .rec_o  (rec_pend),
    .drop_o (drop)
  );

  evt_arb #(.N(NSRC), .IW(IDX_W)) u_arb (
    .req_i (pend),
    .gnt_o (gnt),
    .idx_o (gidx),
    .any_o (gany)
  );

  assign sel_rec = rec_pend[gidx*REC_W +: REC_W];
  assign push[1] = gany && (int'(gidx) <= MODE_I);
  assign push[0] = gany && (int'(gidx) > MODE_I);
  assign pop[0]  = pop_i && !rd_page_i;
  assign pop[1]  = pop_i && rd_page_i;
  assign sdrop[1] = |drop[MODE_I:0];
  assign sdrop[0] = |drop[NSRC-1:WARN_0];

  for (genvar p = 0; p < 2; p++) begin : g_page
    evt_page #(.DEPTH(DEPTH), .REC_W(REC_W)) u_page (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .circ_i  (circ_i),
      .push_i  (push[p]),
      .rec_i   (sel_rec),
      .pop_i   (pop[p]),
      .head_o  (head[p]),
      .cnt_o   (cnt[p]),
      .full_o  (full_o[p]),
      .empty_o (empty[p]),
      .lost_o  (plost[p])
    );
  end

  assign lost_sum = int'(lost_q) + int'(plost[0]) + int'(plost[1]) + $countones(drop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lost_q <= '0;
      ovf_q  <= '0;
    end else begin
      lost_q <= (lost_sum > LOST_MAX) ? LOST_W'(LOST_MAX) : LOST_W'(lost_sum);
      for (int p = 0; p < 2; p++) begin
        if (plost[p] || sdrop[p]) ovf_q[p] <= 1'b1;
        else if (ovf_clr_i)       ovf_q[p] <= 1'b0;
      end
    end
  end

  assign {rd_ts_o, rd_ch_o, rd_val_o, rd_cause_o} = head[rd_page_i];
  assign rd_valid_o = !empty[rd_page_i];
  assign lvl_warn_o = cnt[0];
  assign lvl_crit_o = cnt[1];
  assign ovf_o      = ovf_q;
  assign lost_o     = lost_q;
endmodule

// File: rtl/evt_log_chk.sv
module evt_log_chk #(
  parameter int DEPTH  = 16,
  parameter int LOST_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pop_i,
  input logic              rd_page_i,
  input logic              circ_i,
  input logic              ovf_clr_i,
  input logic              rd_valid_o,
  input logic [CNT_W-1:0]  lvl_warn_o,
  input logic [CNT_W-1:0]  lvl_crit_o,
  input logic [1:0]        full_o,
  input logic [1:0]        ovf_o,
  input logic [LOST_W-1:0] lost_o
);
  // R9
  warn_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o[0] == (int'(lvl_warn_o) == DEPTH));
  // R9
  crit_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o[1] == (int'(lvl_crit_o) == DEPTH));
  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o == ((rd_page_i ? lvl_crit_o : lvl_warn_o) != '0));
  // R8
  warn_ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o[0] && !ovf_clr_i) |=> ovf_o[0]);
  // R8
  crit_ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o[1] && !ovf_clr_i) |=> ovf_o[1]);
  // R8
  lost_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o >= $past(lost_o));
  // R10
  warn_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lvl_warn_o) <= int'($past(lvl_warn_o)) + 1) &&
    (int'(lvl_warn_o) + 1 >= int'($past(lvl_warn_o))));
  // R4
  crit_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && rd_page_i) |=> lvl_crit_o >= $past(lvl_crit_o));
  // R6
  fifo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!circ_i && full_o[0] && !(pop_i && !rd_page_i)) |=> full_o[0]);
endmodule

bind evt_log evt_log_chk #(.DEPTH(DEPTH), .LOST_W(LOST_W), .CNT_W(CNT_W)) u_evt_log_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pop_i      (pop_i),
  .rd_page_i  (rd_page_i),
  .circ_i     (circ_i),
  .ovf_clr_i  (ovf_clr_i),
  .rd_valid_o (rd_valid_o),
  .lvl_warn_o (lvl_warn_o),
  .lvl_crit_o (lvl_crit_o),
  .full_o     (full_o),
  .ovf_o      (ovf_o),
  .lost_o     (lost_o)
);

// File: tb/evt_log_bench.sv
module evt_log_bench;
  localparam int PERIOD = 10;
  localparam int NUM_CH = 4;
  localparam int VAL_W  = 16;
  localparam int TS_W   = 16;
  localparam int DEPTH  = 4;
  localparam int LOST_W = 3;
  localparam int CH_W   = 2;
  localparam int CNT_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0] crit_i = '0, warn_i = '0;
  logic [NUM_CH*VAL_W-1:0] val_i = '0;
  logic [1:0] mode_i = '0;
  logic snap_i = 1'b0;
  logic [CH_W-1:0] snap_ch_i = '0;
  logic circ_i = 1'b0, pop_i = 1'b0, rd_page_i = 1'b0, ovf_clr_i = 1'b0;
  logic rd_valid_o;
  logic [TS_W-1:0] rd_ts_o;
  logic [CH_W-1:0] rd_ch_o;
  logic [VAL_W-1:0] rd_val_o;
  logic [2:0] rd_cause_o;
  logic [CNT_W-1:0] lvl_warn_o, lvl_crit_o;
  logic [1:0] full_o, ovf_o;
  logic [LOST_W-1:0] lost_o;

  logic [15:0] cyc;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= '0; else cyc <= cyc + 1'b1;

  evt_log #(.NUM_CH(NUM_CH), .VAL_W(VAL_W), .TS_W(TS_W), .DEPTH(DEPTH), .LOST_W(LOST_W)) u_evt_log (
    .clk_i(clk), .rst_ni(rst_n), .crit_i(crit_i), .warn_i(warn_i), .val_i(val_i),
    .mode_i(mode_i), .snap_i(snap_i), .snap_ch_i(snap_ch_i), .circ_i(circ_i),
    .pop_i(pop_i), .rd_page_i(rd_page_i), .ovf_clr_i(ovf_clr_i),
    .rd_valid_o(rd_valid_o), .rd_ts_o(rd_ts_o), .rd_ch_o(rd_ch_o), .rd_val_o(rd_val_o),
    .rd_cause_o(rd_cause_o), .lvl_warn_o(lvl_warn_o), .lvl_crit_o(lvl_crit_o),
    .full_o(full_o), .ovf_o(ovf_o), .lost_o(lost_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(input bit crit, input int ch, input logic [15:0] v, output logic [15:0] ts);
    val_i[ch*VAL_W +: VAL_W] = v;
    if (crit) crit_i[ch] = 1'b1; else warn_i[ch] = 1'b1;
    ts = cyc;
    @(negedge clk);
    crit_i = '0;
    warn_i = '0;
  endtask

  task automatic pop_rec(input string tag, input bit pg, input logic [15:0] ts,
                         input int ch, input logic [15:0] v, input int cause);
    rd_page_i = pg;
    #1;
    chk(tag, {rd_valid_o, rd_ts_o, rd_ch_o, rd_val_o, rd_cause_o},
        {1'b1, ts, CH_W'(ch), v, 3'(cause)});
    pop_i = 1'b1;
    @(negedge clk);
    pop_i = 1'b0;
  endtask

  initial begin
    logic [15:0] t;
    logic [15:0] tsa [8];
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 levels", {lvl_warn_o, lvl_crit_o}, '0);
    chk("R1 flags", {rd_valid_o, full_o, ovf_o, lost_o}, '0);
    rd_page_i = 1'b1; #1;
    chk("R1 crit valid", rd_valid_o, 0);
    step(1);

    // R2 R4 single triggers on every channel and page
    for (int c = 0; c < NUM_CH; c++) begin
      fire(1'b0, c, 16'h100 + 16'(c), t);
      step(1);
      chk("R4 warn only", {lvl_warn_o, lvl_crit_o}, {3'd1, 3'd0});
      pop_rec("R2 warn record", 1'b0, t, c, 16'h100 + 16'(c), 2);
      fire(1'b1, c, 16'h200 + 16'(c), t);
      step(1);
      chk("R4 crit only", {lvl_warn_o, lvl_crit_o}, {3'd0, 3'd1});
      pop_rec("R2 crit record", 1'b1, t, c, 16'h200 + 16'(c), 1);
    end

    // R3 mode changes and snapshot
    mode_i = 2'd2; t = cyc; step(2);
    chk("R3 mode page", {lvl_warn_o, lvl_crit_o}, {3'd0, 3'd1});
    pop_rec("R3 mode 0->2", 1'b1, t, 0, 16'h0002, 3);
    mode_i = 2'd1; t = cyc; step(2);
    pop_rec("R3 mode 2->1", 1'b1, t, 0, 16'h0009, 3);
    val_i[2*VAL_W +: VAL_W] = 16'hABCD; snap_ch_i = 2'd2; snap_i = 1'b1; t = cyc;
    step(1); snap_i = 1'b0; step(1);
    chk("R3 snap page", {lvl_warn_o, lvl_crit_o}, {3'd1, 3'd0});
    pop_rec("R3 snapshot", 1'b0, t, 2, 16'hABCD, 4);

    // R5 same-cycle burst
    for (int c = 0; c < NUM_CH; c++) val_i[c*VAL_W +: VAL_W] = 16'h300 + 16'(c);
    crit_i = 4'b1010; warn_i = 4'b1101; mode_i = 2'd3; snap_i = 1'b1; snap_ch_i = 2'd1;
    t = cyc;
    step(1);
    crit_i = '0; warn_i = '0; snap_i = 1'b0;
    step(3);
    chk("R5 critical first", {lvl_crit_o, lvl_warn_o}, {3'd3, 3'd0});
    step(4);
    chk("R5 warnings after", {lvl_crit_o, lvl_warn_o}, {3'd3, 3'd4});
    pop_rec("R5 crit ch1", 1'b1, t, 1, 16'h301, 1);
    pop_rec("R5 crit ch3", 1'b1, t, 3, 16'h303, 1);
    pop_rec("R5 mode", 1'b1, t, 0, 16'h0007, 3);
    pop_rec("R5 warn ch0", 1'b0, t, 0, 16'h300, 2);
    pop_rec("R5 warn ch2", 1'b0, t, 2, 16'h302, 2);
    pop_rec("R5 warn ch3", 1'b0, t, 3, 16'h303, 2);
    pop_rec("R5 snap ch1", 1'b0, t, 1, 16'h301, 4);

    // R6 refuse when full
    circ_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      fire(1'b0, 1, 16'h400 + 16'(k), tsa[k]);
      step(1);
    end
    chk("R9 full level", {lvl_warn_o, full_o}, {3'd4, 2'b01});
    chk("R8 fifo loss", {ovf_o, lost_o}, {2'b01, 3'd2});
    chk("R4 crit untouched", lvl_crit_o, 0);
    for (int k = 0; k < 4; k++) pop_rec("R6 kept oldest", 1'b0, tsa[k], 1, 16'h400 + 16'(k), 2);
    ovf_clr_i = 1'b1; step(1); ovf_clr_i = 1'b0;
    chk("R8 ovf cleared", {ovf_o, lost_o}, {2'b00, 3'd2});

    // R7 overwrite oldest, R4 critical survives
    fire(1'b1, 0, 16'h500, tsa[6]); fire(1'b1, 0, 16'h501, tsa[7]); step(1);
    circ_i = 1'b1;
    for (int k = 0; k < 6; k++) begin
      fire(1'b0, 2, 16'h600 + 16'(k), tsa[k]);
      step(1);
    end
    chk("R7 full level", {lvl_warn_o, full_o}, {3'd4, 2'b01});
    chk("R8 circ loss", {ovf_o, lost_o}, {2'b01, 3'd4});
    chk("R4 crit level", lvl_crit_o, 2);
    for (int k = 2; k < 6; k++) pop_rec("R7 kept newest", 1'b0, tsa[k], 2, 16'h600 + 16'(k), 2);
    pop_rec("R4 crit kept a", 1'b1, tsa[6], 0, 16'h500, 1);
    pop_rec("R4 crit kept b", 1'b1, tsa[7], 0, 16'h501, 1);
    circ_i = 1'b0;
    ovf_clr_i = 1'b1; step(1); ovf_clr_i = 1'b0;

    // R10 pop on empty ignored
    rd_page_i = 1'b0; #1;
    chk("R10 empty valid", rd_valid_o, 0);
    pop_i = 1'b1; step(1); pop_i = 1'b0;
    fire(1'b0, 3, 16'h777, t); step(1);
    chk("R10 empty pop", {lvl_warn_o, lost_o}, {3'd1, 3'd4});
    pop_rec("R10 after empty pop", 1'b0, t, 3, 16'h777, 2);

    // R10 pop and push together on a full page
    for (int k = 0; k < 4; k++) begin
      fire(1'b0, 0, 16'h800 + 16'(k), tsa[k]);
      step(1);
    end
    val_i[0 +: VAL_W] = 16'h804; warn_i[0] = 1'b1; tsa[4] = cyc;
    step(1);
    warn_i = '0; rd_page_i = 1'b0; pop_i = 1'b1;
    step(1);
    pop_i = 1'b0;
    chk("R10 pop+push", {lvl_warn_o, ovf_o, lost_o}, {3'd4, 2'b00, 3'd4});
    for (int k = 1; k < 5; k++) pop_rec("R10 order", 1'b0, tsa[k], 0, 16'h800 + 16'(k), 2);

    // R11 retrigger while pending
    for (int c = 0; c < NUM_CH; c++) val_i[c*VAL_W +: VAL_W] = 16'h900 + 16'(c);
    crit_i = 4'hF; warn_i = 4'h1; t = cyc;
    step(1);
    crit_i = '0; val_i[0 +: VAL_W] = 16'hA01;
    step(1);
    warn_i = '0;
    step(6);
    chk("R11 drop counted", {ovf_o, lost_o}, {2'b01, 3'd5});
    chk("R11 levels", {lvl_crit_o, lvl_warn_o}, {3'd4, 3'd1});
    pop_rec("R11 first kept", 1'b0, t, 0, 16'h900, 2);
    for (int c = 0; c < NUM_CH; c++) pop_rec("R5 crit order", 1'b1, t, c, 16'h900 + 16'(c), 1);

    // R8 saturation
    for (int k = 0; k < 7; k++) begin
      fire(1'b0, 1, 16'hB00 + 16'(k), t);
      step(1);
    end
    chk("R8 lost saturates", lost_o, 7);
    fire(1'b0, 1, 16'hBFF, t); step(1);
    chk("R8 lost stays", lost_o, 7);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule